// File: doc/BRIEF.md
# Single-Wire Pulse-Encoded Bit Transmitter

This block sends bytes to a peripheral over one open-drain data wire. A bit is carried by low pulses, not by a level. Every bit slot opens with a short low start pulse. A one leaves the wire released for the rest of the slot. A zero releases the wire for one pulse width and then pulls it low a second time for one more pulse width. The block drives a single pull-low enable. An external pull-up sets the high level.

Bytes arrive on a valid/ready handshake. A byte goes out least-significant bit first as consecutive slots of fixed length. A byte that is waiting when the current one ends starts in the very next cycle, so the wire never sits idle inside a stream. A receiver elsewhere reports the falling edge of the start pulse of the peripheral's last bit. From that point the transmitter holds off its next byte for the turnaround interval. All durations are given in nanoseconds and converted to whole cycles of the parameterised clock.

Top module: `swt_tx`

## Requirements
- R1: While and directly after reset, `drv_low` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Each duration in cycles is round(ns × CLK_HZ / 1e9), with half rounded up. The defaults are a 38000 ns slot, a 4340 ns pulse and a 93000 ns turnaround. At CLK_HZ = 10 MHz this gives 380, 43 and 930 cycles.
- R3: A byte is taken at a rising edge where `in_valid` and `in_ready` are both 1. `drv_low` and `busy` go to 1 right after that edge. `busy` stays 1 for exactly DATA_W × slot cycles. `drv_low` is 0 whenever `busy` is 0.
- R4: Counting from the edge that starts a slot, the slot lasts slot cycles. `drv_low` is 1 at offsets 0 to pulse−1 of every slot.
- R5: In a slot carrying a one, `drv_low` is 0 from offset pulse to the end of the slot.
- R6: In a slot carrying a zero, `drv_low` is 0 at offsets pulse to 2·pulse−1, 1 at offsets 2·pulse to 3·pulse−1, and 0 for the rest of the slot.
- R7: Slot k of a byte carries bit k of the accepted data, so bit 0 goes first.
- R8: `in_ready` is 1 in the last cycle of a byte when the turnaround window is closed. A byte held valid then starts at the next edge, so slot starts stay exactly one slot apart across bytes.
- R9: After `peer_last_edge` is sampled 1 at edge G, `in_ready` is 0 after edges G to G+turn−2 and 1 after edge G+turn−1. No start pulse is driven before edge G+turn, even while `in_valid` is held.
- R10: A new `peer_last_edge` that arrives while the window is counting restarts the full turnaround interval.
- R11: A `peer_last_edge` that arrives in the same cycle as an acceptance does not stop that byte. The window applies to the byte that follows.
- R12: `in_ready` is 0 during a byte except in its last cycle. Changes on `in_data` after acceptance do not alter the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | A byte is taken at the next edge if valid |
| in_data | input | DATA_W | Byte to send, bit 0 first |
| peer_last_edge | input | 1 | One-cycle mark: start pulse of the peripheral's last bit fell |
| busy | output | 1 | Bit slots are in progress |
| drv_low | output | 1 | 1 pulls the shared wire low; 0 releases it |

## Verification
Two events can land on the same edge: a turnaround mark from the receive side, and the transmitter's own byte boundary (an acceptance, or the last cycle of a byte with the next byte waiting). The bench raises `peer_last_edge` in the very cycle a byte is accepted and expects that byte's slots to follow unchanged. It also raises the mark 100 cycles before a streamed byte ends. The following byte must then wait an exact number of cycles, with the wire released the whole time. Every slot is compared cycle by cycle against a pattern built from the pulse and slot lengths.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    // Nanoseconds to whole clock cycles, rounded to nearest (half up).
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned clk_hz);
        longint unsigned scaled;
        scaled = ns * clk_hz + NS_PER_S / 2;
        return 32'(scaled / NS_PER_S);
    endfunction

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // Per-cycle control decisions of the top-level sequencer.
    typedef struct packed {
        logic accept;
        logic advance;
        logic byte_end;
        logic slot_start;
    } tx_ctrl_t;

endpackage

// File: rtl/swt_gap_guard.sv
module swt_gap_guard #(
    parameter int unsigned TURN_CYC = 9300
) (
    input  logic clk,
    input  logic rst,
    input  logic peer_edge,
    output logic gap_open
);
    localparam int unsigned GW = $clog2(TURN_CYC + 1);
    localparam logic [GW-1:0] RELOAD = GW'(TURN_CYC - 1);

    logic [GW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (peer_edge)
            remain <= RELOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign gap_open = (remain == '0);

    // R10: a mark always closes the window on the following cycle
    assert_mark_closes_R10: assert property (@(posedge clk) disable iff (rst)
        peer_edge |=> !gap_open);

endmodule

// File: rtl/swt_bit_seq.sv
module swt_bit_seq #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              advance,
    output logic              next_bit,
    output logic              last_bit
);
    localparam int unsigned IW = $clog2(DATA_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    logic [DATA_W-2:0] rest;
    logic [IW-1:0]     idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rest <= '0;
            idx  <= '0;
        end else if (load) begin
            rest <= load_data[DATA_W-1:1];
            idx  <= '0;
        end else if (advance) begin
            rest <= rest >> 1;
            idx  <= idx + 1'b1;
        end
    end

    // Bit that the slot starting at the coming edge carries.
    assign next_bit = load ? load_data[0] : rest[0];
    assign last_bit = (idx == LAST_IDX);

    // R7: the sequencer is never asked to step past the final bit
    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last_bit);

endmodule

// File: rtl/swt_slot_timer.sv
module swt_slot_timer #(
    parameter int unsigned BIT_CYC   = 3800,
    parameter int unsigned PULSE_CYC = 434
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_bit,
    output logic drv_low,
    output logic slot_last
);
    localparam int unsigned CW = $clog2(BIT_CYC);
    localparam logic [CW-1:0] LAST_C = CW'(BIT_CYC - 1);
    localparam logic [CW-1:0] P1     = CW'(PULSE_CYC);
    localparam logic [CW-1:0] P2     = CW'(2 * PULSE_CYC);
    localparam logic [CW-1:0] P3     = CW'(3 * PULSE_CYC);

    logic          run, run_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          bit_q, bit_n;
    logic          drv_n;

    assign slot_last = run && (cnt == LAST_C);

    always_comb begin
        run_n = run;
        cnt_n = cnt;
        bit_n = bit_q;
        if (start) begin
            run_n = 1'b1;
            cnt_n = '0;
            bit_n = start_bit;
        end else if (slot_last) begin
            run_n = 1'b0;
            cnt_n = '0;
        end else if (run) begin
            cnt_n = cnt + 1'b1;
        end
        // Registered wire drive: computed from next-state so it lines up with cnt.
        drv_n = run_n && ((cnt_n < P1) ||
                          (!bit_n && (cnt_n >= P2) && (cnt_n < P3)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            cnt     <= '0;
            bit_q   <= 1'b0;
            drv_low <= 1'b0;
        end else begin
            run     <= run_n;
            cnt     <= cnt_n;
            bit_q   <= bit_n;
            drv_low <= drv_n;
        end
    end

    // R4: the wire is only ever pulled low at a start or second-pulse boundary
    assert_pulse_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_low) |-> (cnt == '0 || cnt == P2));
    // R5: a one keeps the wire released after its start pulse
    assert_one_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (run && bit_q && cnt >= P1) |-> !drv_low);
    // R6: a zero pulls low again at twice the pulse width
    assert_zero_second_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !bit_q && cnt == P2) |-> drv_low);

endmodule

// File: rtl/swt_tx.sv
module swt_tx
    import swt_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned BIT_NS   = 38_000,
    parameter int unsigned PULSE_NS = 4_340,
    parameter int unsigned TURN_NS  = 93_000,
    parameter int unsigned DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              peer_last_edge,
    output logic              busy,
    output logic              drv_low
);
    localparam int unsigned BIT_CYC   = ns_to_cycles(BIT_NS, CLK_HZ);
    localparam int unsigned PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
    localparam int unsigned TURN_CYC  = ns_to_cycles(TURN_NS, CLK_HZ);

    tx_state_e state;
    tx_ctrl_t  ctl;
    logic      gap_open;
    logic      slot_last;
    logic      last_bit;
    logic      next_bit;

    always_comb begin
        ctl.byte_end   = (state == TX_SEND) && slot_last && last_bit;
        ctl.advance    = (state == TX_SEND) && slot_last && !last_bit;
        ctl.accept     = in_valid && gap_open &&
                         ((state == TX_IDLE) || ctl.byte_end);
        ctl.slot_start = ctl.accept || ctl.advance;
    end

    assign in_ready = gap_open && ((state == TX_IDLE) || ctl.byte_end);
    assign busy     = (state == TX_SEND);

    always_ff @(posedge clk) begin
        if (rst)
            state <= TX_IDLE;
        else if (ctl.accept)
            state <= TX_SEND;
        else if (ctl.byte_end)
            state <= TX_IDLE;
    end

    swt_gap_guard #(.TURN_CYC(TURN_CYC)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .peer_edge (peer_last_edge),
        .gap_open  (gap_open)
    );

    swt_bit_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.accept),
        .load_data (in_data),
        .advance   (ctl.advance),
        .next_bit  (next_bit),
        .last_bit  (last_bit)
    );

    swt_slot_timer #(.BIT_CYC(BIT_CYC), .PULSE_CYC(PULSE_CYC)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .start     (ctl.slot_start),
        .start_bit (next_bit),
        .drv_low   (drv_low),
        .slot_last (slot_last)
    );

    // R3: acceptance opens a slot with a start pulse on the next cycle
    assert_accept_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.accept |=> (busy && drv_low));
    // R3: the wire is released whenever no byte is in flight
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drv_low);
    // R9: nothing starts while the turnaround window is closed
    assert_gap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!gap_open && !busy) |=> !drv_low);

endmodule

// File: tb/tb_swt_tx.sv
module tb_swt_tx;
    localparam int P    = 43;
    localparam int BIT  = 380;
    localparam int TURN = 930;
    localparam int NB   = 8;
    localparam int NVEC = 4;
    localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       peer_last_edge = 1'b0;
    logic       in_ready, busy, drv_low;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    swt_tx #(.CLK_HZ(10_000_000), .DATA_W(8)) dut (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .peer_last_edge (peer_last_edge),
        .busy           (busy),
        .drv_low        (drv_low)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_low(input logic [7:0] d, input int t);
        int s;
        int c;
        s = t / BIT;
        c = t % BIT;
        if (c < P) return 1'b1;
        if (!d[s] && c >= 2 * P && c < 3 * P) return 1'b1;
        return 1'b0;
    endfunction

    // Offer a byte and return at the negedge where in_ready is seen high.
    task automatic begin_send(input logic [7:0] d, input bit peer);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        peer_last_edge = peer;
    endtask

    // Watch one byte from t=0 (first negedge after acceptance).
    task automatic watch_byte(input logic [7:0] d, input bit have_next,
                              input logic [7:0] nxt, input bit ready_end,
                              input int peer_at, input string tag);
        for (int s = 0; s < NB; s++) begin
            int bad;
            bad = 0;
            for (int c = 0; c < BIT; c++) begin
                int t;
                t = s * BIT + c;
                @(negedge clk);
                if (t == 0) peer_last_edge = 1'b0;
                if (drv_low !== exp_low(d, t)) bad++;
                if (busy !== 1'b1) bad++;
                if (in_ready !== ((t == NB * BIT - 1) && ready_end)) bad++;
                if (t == 3 * BIT) in_data = ~d;          // R12 disturbance
                if (t == peer_at) peer_last_edge = 1'b1;
                if (t == peer_at + 1) peer_last_edge = 1'b0;
                if (t == NB * BIT - 1) begin
                    in_valid = have_next;
                    in_data  = nxt;
                end
            end
            chk(bad == 0, d[s] ? "R5" : "R6",
                $sformatf("%s slot %0d byte %02h (R2 R4 R7 R12)", tag, s, d), bad, 0);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=1 expected=0");
        report();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(drv_low === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R1",
            "outputs during reset", {drv_low, busy, in_ready}, 1);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(drv_low === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R1",
            "outputs after reset", {drv_low, busy, in_ready}, 1);

        // Table walk: back-to-back stream (R3 R5 R6 R7 R8)
        begin_send(VEC[0], 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            watch_byte(VEC[i], i < NVEC - 1, (i < NVEC - 1) ? VEC[(i + 1) % NVEC] : 8'h00,
                       1'b1, -1, "R8 stream");
        end
        @(negedge clk);
        chk(busy === 1'b0 && drv_low === 1'b0, "R3", "idle after stream",
            {busy, drv_low}, 0);

        // R9: turnaround window blocks a waiting byte
        peer_last_edge = 1'b1;
        @(negedge clk);
        peer_last_edge = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'h96;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < TURN; k++) begin
                if (k > 0) @(negedge clk);
                if (in_ready !== (k == TURN - 1)) bad++;
                if (drv_low !== 1'b0 || busy !== 1'b0) bad++;
            end
            chk(bad == 0, "R9", "ready/line over turnaround window", bad, 0);
        end
        watch_byte(8'h96, 1'b0, 8'h00, 1'b1, -1, "R9 after gap");

        // R10: retrigger restarts the window
        @(negedge clk);
        peer_last_edge = 1'b1;
        @(negedge clk);
        peer_last_edge = 1'b0;
        repeat (499) @(negedge clk);
        peer_last_edge = 1'b1;
        @(negedge clk);
        peer_last_edge = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < TURN; k++) begin
                if (k > 0) @(negedge clk);
                if (in_ready !== (k == TURN - 1)) bad++;
            end
            chk(bad == 0, "R10", "window length after retrigger", bad, 0);
        end

        // R11: mark in the accept cycle, then a mark late in a streamed byte
        begin_send(8'h5A, 1'b1);
        watch_byte(8'h5A, 1'b1, 8'hC3, 1'b1, -1, "R11 coincident mark");
        watch_byte(8'hC3, 1'b1, 8'h81, 1'b0, NB * BIT - 100, "R11 late mark");
        begin
            int n;
            int bad;
            n = 0;
            bad = 0;
            while (!in_ready && n < 5000) begin
                @(negedge clk);
                n++;
                if (drv_low !== 1'b0 || busy !== 1'b0) bad++;
            end
            chk(n == TURN - 99, "R9", "hold-off cycles after late mark", n, TURN - 99);
            chk(bad == 0, "R9", "line released during hold-off", bad, 0);
        end
        watch_byte(8'h81, 1'b0, 8'h00, 1'b1, -1, "R9 held byte");
        @(negedge clk);
        chk(busy === 1'b0 && drv_low === 1'b0 && in_ready === 1'b1, "R3",
            "idle at end", {busy, drv_low, in_ready}, 1);

        report();
    end
endmodule